// File: doc/BRIEF.md
# Sixteen-bit Register-Pair Arithmetic Unit

This block runs the 16-bit arithmetic group of a small 8-bit processor core. It owns six register pairs: BC, DE, HL, SP and the two index pairs IX and IY. It also owns the six arithmetic flags. A sequencer elsewhere presents an optional prefix byte and an opcode byte and raises a one-cycle start strobe. The unit decodes the pair, computes the result and writes it back. It then raises a done pulse after the nominal cycle cost of that instruction.

Add and subtract run as two passes through a single half-width ALU. The low half goes first. The high half follows and takes the carry or borrow from the low half. The half-carry flag is taken from the middle of the high pass. Sign, zero and overflow come from the whole result. Increment and decrement use a separate path and never touch the flags. The pair width is a parameter: at the default of 16 each pass is one byte.

Top module: `regpair_alu`

## Requirements
- R1: After a synchronous reset, all six pairs read zero, all flags read zero, and done_o and illegal_o are low.
- R2: With prefix 0x00 (meaning no prefix), opcode 00 ff1 001 adds the pair selected by field ff to HL, modulo 2^PAIR_W. Field ff selects 00=BC, 01=DE, 10=HL, 11=SP. C takes the carry out of the top bit. H takes the carry out of bit PAIR_W-PAIR_W/4-1, which is bit 11 at width 16. N clears, and S, Z and V keep their values. flags_o packs the flags as bit5=S, bit4=Z, bit3=H, bit2=V, bit1=N, bit0=C.
- R3: With prefix 0xED, opcode 01 ff1 010 computes HL = HL + pair + C. It sets S from the top result bit and sets Z when the result is zero. V shows two's-complement overflow. H and C follow the same rule as R2, and N clears.
- R4: With prefix 0xED, opcode 01 ff0 010 computes HL = HL - pair - C. C shows a borrow out of the top bit. H shows a borrow from bit PAIR_W-PAIR_W/4. V shows signed overflow, S and Z follow the result, and N sets.
- R5: With prefix 0xDD the add form 00 ff1 001 targets IX, and with prefix 0xFD it targets IY. In these forms field 10 selects the index pair itself. The flag rules are those of R2.
- R6: With prefix 0x00, opcode 00 ff0 011 increments the selected pair and 00 ff1 011 decrements it, both wrapping modulo 2^PAIR_W.
- R7: Prefix 0xDD or 0xFD followed by 0x23 increments IX or IY. The same prefixes followed by 0x2B decrement IX or IY.
- R8: Every increment and decrement form leaves all six flags unchanged.
- R9: done_o is high for exactly one cycle. It goes high N rising edges after the edge that accepts start_i, where N is 11 for the unprefixed add, 15 for the index adds and for add-with-carry and subtract-with-borrow, 6 for unprefixed increment or decrement, and 10 for index increment or decrement.
- R10: Any other prefix or opcode is illegal. For an illegal instruction, done_o and illegal_o pulse together one edge after acceptance, and no pair or flag changes.
- R11: start_i is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept the presented instruction |
| prefix_i | input | 8 | Prefix byte, 0x00 when absent |
| opcode_i | input | 8 | Opcode byte |
| bc_o | output | PAIR_W | Pair BC |
| de_o | output | PAIR_W | Pair DE |
| hl_o | output | PAIR_W | Pair HL |
| sp_o | output | PAIR_W | Pair SP |
| ix_o | output | PAIR_W | Index pair IX |
| iy_o | output | PAIR_W | Index pair IY |
| flags_o | output | 6 | {S,Z,H,V,N,C} |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Pulses with done_o for an undecodable instruction |

## Verification
The bench builds the unit with PAIR_W=8, so each pass is four bits wide and every pair has only 256 values. That small width lets a long instruction stream drive every pair through carry, borrow, half-carry, overflow and zero results, including wrap-around. It also runs every opcode under each of the four legal prefix values and under one foreign prefix, which covers the whole decode space. The cycle costs keep their default values, so the timing seen is the timing of the 16-bit build.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

  localparam int NPAIR = 6;

  localparam logic [7:0] PFX_NONE  = 8'h00;
  localparam logic [7:0] PFX_EXT   = 8'hED;
  localparam logic [7:0] PFX_IDX_X = 8'hDD;
  localparam logic [7:0] PFX_IDX_Y = 8'hFD;

  localparam logic [7:0] OP_IDX_INC = 8'h23;
  localparam logic [7:0] OP_IDX_DEC = 8'h2B;

  typedef enum logic [2:0] {
    PR_BC = 3'd0,
    PR_DE = 3'd1,
    PR_HL = 3'd2,
    PR_SP = 3'd3,
    PR_IX = 3'd4,
    PR_IY = 3'd5
  } pair_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_ADD  = 3'd1,
    K_ADC  = 3'd2,
    K_SBC  = 3'd3,
    K_INC  = 3'd4,
    K_DEC  = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e kind;
    pair_e dst;
    pair_e src;
    logic  bad;
  } dec_t;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic v;
    logic n;
    logic c;
  } flags_t;

  // Field value 2 names the accumulator pair of the instruction itself.
  function automatic pair_e field_pair(input logic [1:0] f, input pair_e self);
    case (f)
      2'b00:   return PR_BC;
      2'b01:   return PR_DE;
      2'b10:   return self;
      default: return PR_SP;
    endcase
  endfunction

endpackage

// File: rtl/rp_decode.sv
module rp_decode
  import regpair_pkg::*;
#(
  parameter int CW             = 4,
  parameter int CYC_ADD_SHORT  = 11,
  parameter int CYC_LONG       = 15,
  parameter int CYC_STEP_SHORT = 6,
  parameter int CYC_STEP_IDX   = 10
) (
  input  logic [7:0]    prefix_i,
  input  logic [7:0]    opcode_i,
  output dec_t          dec_o,
  output logic [CW-1:0] cost_o
);

  logic [1:0] f;
  pair_e      idx;

  assign f   = opcode_i[5:4];
  assign idx = (prefix_i == PFX_IDX_Y) ? PR_IY : PR_IX;

  always_comb begin
    dec_o  = '{K_NONE, PR_HL, PR_HL, 1'b1};
    cost_o = CW'(1);
    case (prefix_i)
      PFX_NONE: begin
        if (opcode_i[7:6] == 2'b00) begin
          case (opcode_i[3:0])
            4'h9: begin
              dec_o  = '{K_ADD, PR_HL, field_pair(f, PR_HL), 1'b0};
              cost_o = CW'(CYC_ADD_SHORT);
            end
            4'h3: begin
              dec_o  = '{K_INC, field_pair(f, PR_HL), field_pair(f, PR_HL), 1'b0};
              cost_o = CW'(CYC_STEP_SHORT);
            end
            4'hB: begin
              dec_o  = '{K_DEC, field_pair(f, PR_HL), field_pair(f, PR_HL), 1'b0};
              cost_o = CW'(CYC_STEP_SHORT);
            end
            default: ;
          endcase
        end
      end
      PFX_EXT: begin
        if (opcode_i[7:6] == 2'b01) begin
          case (opcode_i[3:0])
            4'hA: begin
              dec_o  = '{K_ADC, PR_HL, field_pair(f, PR_HL), 1'b0};
              cost_o = CW'(CYC_LONG);
            end
            4'h2: begin
              dec_o  = '{K_SBC, PR_HL, field_pair(f, PR_HL), 1'b0};
              cost_o = CW'(CYC_LONG);
            end
            default: ;
          endcase
        end
      end
      PFX_IDX_X, PFX_IDX_Y: begin
        if (opcode_i[7:6] == 2'b00 && opcode_i[3:0] == 4'h9) begin
          dec_o  = '{K_ADD, idx, field_pair(f, idx), 1'b0};
          cost_o = CW'(CYC_LONG);
        end else if (opcode_i == OP_IDX_INC) begin
          dec_o  = '{K_INC, idx, idx, 1'b0};
          cost_o = CW'(CYC_STEP_IDX);
        end else if (opcode_i == OP_IDX_DEC) begin
          dec_o  = '{K_DEC, idx, idx, 1'b0};
          cost_o = CW'(CYC_STEP_IDX);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rp_byte_alu.sv
module rp_byte_alu #(
  parameter int HW = 8
) (
  input  logic [HW-1:0] a_i,
  input  logic [HW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [HW-1:0] res_o,
  output logic          cout_o,
  output logic          hc_o,
  output logic          ovf_o
);

  localparam int Q = HW / 2;

  logic [HW-1:0] bx;
  logic          ci;
  logic [HW:0]   full;

  // Subtraction as a + ~b + ~borrow; carries flip into borrows on the way out.
  assign bx   = sub_i ? ~b_i : b_i;
  assign ci   = sub_i ^ cin_i;
  assign full = {1'b0, a_i} + {1'b0, bx} + {{HW{1'b0}}, ci};

  assign res_o  = full[HW-1:0];
  assign cout_o = full[HW] ^ sub_i;
  assign hc_o   = a_i[Q] ^ bx[Q] ^ full[Q] ^ sub_i;
  assign ovf_o  = (a_i[HW-1] == bx[HW-1]) && (full[HW-1] != a_i[HW-1]);

endmodule

// File: rtl/rp_pairfile.sv
module rp_pairfile
  import regpair_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  pair_e                      wsel_i,
  input  logic [W-1:0]               wdata_i,
  input  pair_e                      rsel_a_i,
  input  pair_e                      rsel_b_i,
  output logic [W-1:0]               rdata_a_o,
  output logic [W-1:0]               rdata_b_o,
  output logic [NPAIR-1:0][W-1:0]    pairs_o
);

  logic [NPAIR-1:0][W-1:0] pairs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pairs_q <= '0;
    end else if (we_i) begin
      pairs_q[wsel_i] <= wdata_i;
    end
  end

  assign rdata_a_o = pairs_q[rsel_a_i];
  assign rdata_b_o = pairs_q[rsel_b_i];
  assign pairs_o   = pairs_q;

endmodule

// File: rtl/regpair_alu.sv
module regpair_alu
  import regpair_pkg::*;
#(
  parameter int PAIR_W         = 16,
  parameter int CYC_ADD_SHORT  = 11,
  parameter int CYC_LONG       = 15,
  parameter int CYC_STEP_SHORT = 6,
  parameter int CYC_STEP_IDX   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [7:0]        prefix_i,
  input  logic [7:0]        opcode_i,
  output logic [PAIR_W-1:0] bc_o,
  output logic [PAIR_W-1:0] de_o,
  output logic [PAIR_W-1:0] hl_o,
  output logic [PAIR_W-1:0] sp_o,
  output logic [PAIR_W-1:0] ix_o,
  output logic [PAIR_W-1:0] iy_o,
  output logic [5:0]        flags_o,
  output logic              done_o,
  output logic              illegal_o
);

  localparam int HW      = PAIR_W / 2;
  localparam int MAX_A   = (CYC_ADD_SHORT > CYC_LONG) ? CYC_ADD_SHORT : CYC_LONG;
  localparam int MAX_B   = (CYC_STEP_SHORT > CYC_STEP_IDX) ? CYC_STEP_SHORT : CYC_STEP_IDX;
  localparam int CYC_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(CYC_MAX + 1);

  dec_t                    dec;
  logic [CW-1:0]           dec_cost;
  logic [PAIR_W-1:0]       rd_a, rd_b;
  logic [NPAIR-1:0][PAIR_W-1:0] pairs;

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  kind_e             kind_q;
  pair_e             dst_q;
  logic              bad_q;
  logic [PAIR_W-1:0] a_q, b_q;
  logic [HW-1:0]     lo_q, hi_q;
  logic              midc_q, topc_q, hc_q, hv_q;
  flags_t            flags_q;
  logic              done_q, illegal_q;

  logic              accept, finish, arith, pass_lo, pass_hi;
  logic [HW-1:0]     alu_a, alu_b, alu_res;
  logic              alu_cin, alu_sub, alu_cout, alu_hc, alu_ovf;
  logic              we;
  logic [PAIR_W-1:0] wdata;

  rp_decode #(
    .CW(CW),
    .CYC_ADD_SHORT(CYC_ADD_SHORT),
    .CYC_LONG(CYC_LONG),
    .CYC_STEP_SHORT(CYC_STEP_SHORT),
    .CYC_STEP_IDX(CYC_STEP_IDX)
  ) u_decode (
    .prefix_i(prefix_i),
    .opcode_i(opcode_i),
    .dec_o(dec),
    .cost_o(dec_cost)
  );

  rp_pairfile #(.W(PAIR_W)) u_pairs (
    .clk(clk),
    .rst(rst),
    .we_i(we),
    .wsel_i(dst_q),
    .wdata_i(wdata),
    .rsel_a_i(dec.dst),
    .rsel_b_i(dec.src),
    .rdata_a_o(rd_a),
    .rdata_b_o(rd_b),
    .pairs_o(pairs)
  );

  assign accept  = start_i && !busy_q;
  assign finish  = busy_q && (cnt_q == CW'(1));
  assign arith   = (kind_q == K_ADD) || (kind_q == K_ADC) || (kind_q == K_SBC);
  assign pass_lo = busy_q && arith && (cnt_q == CW'(3));
  assign pass_hi = busy_q && arith && (cnt_q == CW'(2));

  // One shared half-width ALU: low half first, then high half.
  assign alu_a   = pass_lo ? a_q[HW-1:0] : a_q[PAIR_W-1:HW];
  assign alu_b   = pass_lo ? b_q[HW-1:0] : b_q[PAIR_W-1:HW];
  assign alu_cin = pass_lo ? ((kind_q != K_ADD) && flags_q.c) : midc_q;
  assign alu_sub = (kind_q == K_SBC);

  rp_byte_alu #(.HW(HW)) u_alu (
    .a_i(alu_a),
    .b_i(alu_b),
    .cin_i(alu_cin),
    .sub_i(alu_sub),
    .res_o(alu_res),
    .cout_o(alu_cout),
    .hc_o(alu_hc),
    .ovf_o(alu_ovf)
  );

  assign we = finish && (kind_q != K_NONE);

  always_comb begin
    case (kind_q)
      K_INC:   wdata = a_q + PAIR_W'(1);
      K_DEC:   wdata = a_q - PAIR_W'(1);
      default: wdata = {hi_q, lo_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      kind_q    <= K_NONE;
      dst_q     <= PR_BC;
      bad_q     <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      midc_q    <= 1'b0;
      topc_q    <= 1'b0;
      hc_q      <= 1'b0;
      hv_q      <= 1'b0;
      flags_q   <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= finish;
      illegal_q <= finish && bad_q;

      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= dec_cost;
        kind_q <= dec.kind;
        dst_q  <= dec.dst;
        bad_q  <= dec.bad;
        a_q    <= rd_a;
        b_q    <= rd_b;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (finish) busy_q <= 1'b0;
      end

      if (pass_lo) begin
        lo_q   <= alu_res;
        midc_q <= alu_cout;
      end

      if (pass_hi) begin
        hi_q   <= alu_res;
        topc_q <= alu_cout;
        hc_q   <= alu_hc;
        hv_q   <= alu_ovf;
      end

      if (finish) begin
        case (kind_q)
          K_ADD: begin
            flags_q.h <= hc_q;
            flags_q.n <= 1'b0;
            flags_q.c <= topc_q;
          end
          K_ADC, K_SBC: begin
            flags_q.s <= hi_q[HW-1];
            flags_q.z <= ({hi_q, lo_q} == '0);
            flags_q.h <= hc_q;
            flags_q.v <= hv_q;
            flags_q.n <= (kind_q == K_SBC);
            flags_q.c <= topc_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign bc_o      = pairs[0];
  assign de_o      = pairs[1];
  assign hl_o      = pairs[2];
  assign sp_o      = pairs[3];
  assign ix_o      = pairs[4];
  assign iy_o      = pairs[5];
  assign flags_o   = flags_q;
  assign done_o    = done_q;
  assign illegal_o = illegal_q;

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11: a running count only steps down, whatever start_i does
  p_busy_ignores_start_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q > CW'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));

  // R8: increment and decrement completions leave the flags alone
  p_step_keeps_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (finish && (kind_q == K_INC || kind_q == K_DEC)) |=> $stable(flags_q));

  // R2: plain adds keep sign, zero and overflow
  p_add_keeps_szv_r2: assert property (@(posedge clk) disable iff (rst)
    (finish && kind_q == K_ADD) |=>
      ($stable(flags_q.s) && $stable(flags_q.z) && $stable(flags_q.v)));

  // R10: an illegal completion changed neither pairs nor flags
  p_illegal_no_change_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> ($stable(pairs) && $stable(flags_q) && done_q));

endmodule

// File: tb/regpair_alu_tb.sv
module regpair_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int LOWB = W - W / 4;
  localparam int LOWM = (1 << LOWB) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [7:0]   pfx = 8'h00;
  logic [7:0]   opc = 8'h00;
  logic [W-1:0] bc, de, hl, sp, ix, iy;
  logic [5:0]   flags;
  logic         done, ill;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regpair_alu #(.PAIR_W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .prefix_i(pfx), .opcode_i(opc),
    .bc_o(bc), .de_o(de), .hl_o(hl), .sp_o(sp), .ix_o(ix), .iy_o(iy),
    .flags_o(flags), .done_o(done), .illegal_o(ill)
  );

  int checks = 0;
  int errors = 0;
  int m[6];
  bit fs, fz, fh, fv, fn, fc;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dut_pair(input int i);
    case (i)
      0: return int'(bc);
      1: return int'(de);
      2: return int'(hl);
      3: return int'(sp);
      4: return int'(ix);
      default: return int'(iy);
    endcase
  endfunction

  task automatic check_state(input string rtag, input string ftag);
    int ef;
    for (int i = 0; i < 6; i++) chk(dut_pair(i) == m[i], rtag, dut_pair(i), m[i]);
    ef = int'({fs, fz, fh, fv, fn, fc});
    chk(int'(flags) == ef, ftag, int'(flags), ef);
  endtask

  // Reference model built from the requirements; kinds: 0 none,1 add,2 adc,3 sbc,4 inc,5 dec.
  task automatic model_op(input logic [7:0] p, input logic [7:0] o,
                          output int cost, output bit bad,
                          output string rtag, output string ftag);
    int f, kind, dst, src, a, b, r, c, idx;
    f = int'(o[5:4]);
    idx = (p == 8'hFD) ? 5 : 4;
    kind = 0; dst = 0; src = 0; cost = 1;
    rtag = "R10 pairs"; ftag = "R10 flags";
    if (p == 8'h00 && o[7:6] == 2'b00) begin
      if (o[3:0] == 4'h9) begin kind = 1; dst = 2; src = f; cost = 11; rtag = "R2 pairs"; ftag = "R2 flags"; end
      else if (o[3:0] == 4'h3) begin kind = 4; dst = f; cost = 6; rtag = "R6 pairs"; ftag = "R8 flags"; end
      else if (o[3:0] == 4'hB) begin kind = 5; dst = f; cost = 6; rtag = "R6 pairs"; ftag = "R8 flags"; end
    end else if (p == 8'hED && o[7:6] == 2'b01) begin
      if (o[3:0] == 4'hA) begin kind = 2; dst = 2; src = f; cost = 15; rtag = "R3 pairs"; ftag = "R3 flags"; end
      else if (o[3:0] == 4'h2) begin kind = 3; dst = 2; src = f; cost = 15; rtag = "R4 pairs"; ftag = "R4 flags"; end
    end else if (p == 8'hDD || p == 8'hFD) begin
      if (o[7:6] == 2'b00 && o[3:0] == 4'h9) begin
        kind = 1; dst = idx; src = (f == 2) ? idx : f; cost = 15; rtag = "R5 pairs"; ftag = "R5 flags";
      end else if (o == 8'h23) begin kind = 4; dst = idx; cost = 10; rtag = "R7 pairs"; ftag = "R8 flags"; end
      else if (o == 8'h2B) begin kind = 5; dst = idx; cost = 10; rtag = "R7 pairs"; ftag = "R8 flags"; end
    end
    bad = (kind == 0);
    a = m[dst];
    b = m[src];
    case (kind)
      1: begin
        r = a + b;
        fh = (((a & LOWM) + (b & LOWM)) >> LOWB) != 0;
        fc = (r >> W) != 0;
        fn = 1'b0;
        m[dst] = r & MASK;
      end
      2: begin
        c = fc ? 1 : 0;
        r = a + b + c;
        fh = (((a & LOWM) + (b & LOWM) + c) >> LOWB) != 0;
        fc = (r >> W) != 0;
        r = r & MASK;
        fs = ((r >> (W - 1)) & 1) != 0;
        fz = (r == 0);
        fv = (((a >> (W - 1)) & 1) == ((b >> (W - 1)) & 1)) && (((r >> (W - 1)) & 1) != ((a >> (W - 1)) & 1));
        fn = 1'b0;
        m[dst] = r;
      end
      3: begin
        c = fc ? 1 : 0;
        fc = a < (b + c);
        fh = (a & LOWM) < ((b & LOWM) + c);
        r = (a - b - c) & MASK;
        fs = ((r >> (W - 1)) & 1) != 0;
        fz = (r == 0);
        fv = (((a >> (W - 1)) & 1) != ((b >> (W - 1)) & 1)) && (((r >> (W - 1)) & 1) != ((a >> (W - 1)) & 1));
        fn = 1'b1;
        m[dst] = r;
      end
      4: m[dst] = (a + 1) & MASK;
      5: m[dst] = (a - 1) & MASK;
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [7:0] p, input logic [7:0] o, input bit poke);
    int cost, n;
    bit bad;
    string rt, ft;
    model_op(p, o, cost, bad, rt, ft);
    pfx = p;
    opc = o;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin start = 1'b1; pfx = 8'h00; opc = 8'h03; end
      if (poke && n == 3) start = 1'b0;
    end
    chk(n == cost, bad ? "R10 cycles" : "R9 cycles", n, cost);
    chk(ill == bad, "R10 illegal", int'(ill), int'(bad));
    check_state(poke ? {rt, " R11"} : rt, poke ? {ft, " R11"} : ft);
    @(negedge clk);
    chk(done == 1'b0, "R9 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] p, o;
    logic [1:0] f;
    for (int i = 0; i < 6; i++) m[i] = 0;
    {fs, fz, fh, fv, fn, fc} = 6'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 pairs", "R1 flags");
    chk(done == 1'b0 && ill == 1'b0, "R1 strobes", int'({done, ill}), 0);

    // Whole decode space under each legal prefix and one foreign prefix.
    for (int pi = 0; pi < 5; pi++) begin
      case (pi)
        0: p = 8'h00;
        1: p = 8'hED;
        2: p = 8'hDD;
        3: p = 8'hFD;
        default: p = 8'h55;
      endcase
      for (int oi = 0; oi < 256; oi++) run_op(p, 8'(oi), 1'b0);
    end

    // Long legal stream that reaches carries, borrows and overflow.
    for (int i = 0; i < 2500; i++) begin
      lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      f = lfsr[4:3];
      case (lfsr[2:0])
        3'd0: begin p = 8'h00; o = {2'b00, f, 4'h9}; end
        3'd1: begin p = 8'hED; o = {2'b01, f, 4'hA}; end
        3'd2: begin p = 8'hED; o = {2'b01, f, 4'h2}; end
        3'd3: begin p = 8'hDD; o = {2'b00, f, 4'h9}; end
        3'd4: begin p = 8'hFD; o = {2'b00, f, 4'h9}; end
        3'd5: begin p = 8'h00; o = {2'b00, f, 4'h3}; end
        3'd6: begin p = 8'h00; o = {2'b00, f, 4'hB}; end
        default: begin p = lfsr[5] ? 8'hDD : 8'hFD; o = lfsr[6] ? 8'h23 : 8'h2B; end
      endcase
      run_op(p, o, (i % 7) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule